// File: doc/BRIEF.md
# Link-Layer Replay Transmitter

This block sits on the transmit side of a point-to-point serial link, between a packet source and the link framer. Every packet that the source hands over is copied into a replay store, then sent out framed: a leading word that carries a 12-bit sequence number, the packet words unchanged, and a trailing 32-bit CRC word. A stored copy stays in the store until the far end positively acknowledges it.

The receive path reports acknowledgements on a small side interface. Each report carries a sequence number and a flag that marks it as a negative acknowledgement. Acknowledgements are cumulative: one report releases every held packet up to and including the number it carries. A negative acknowledgement, or a replay timer that runs out while packets are still unacknowledged, rewinds the sender. Every packet still held is then sent again in its original order, with the same sequence number and the same CRC. The source is held off while a replay is pending or running, so replayed and new packets never mix on the link.

Both packet interfaces use a valid/ready word handshake with first-word and last-word markers. The number of packets held at once is bounded by a parameter. When that many are held, the source is stalled until an acknowledgement frees space.

Top module: `lrt_replay_tx`

## Requirements
- R1: Each output frame is one header word marked `m_first`, then the packet's words in order, then one CRC word marked `m_last`. The header holds the sequence number in bits [11:0] and zeros in bits [31:12]. A frame is at least three words long.
- R2: The first packet after reset is numbered 0. Each later new packet is numbered one more than the one before it, modulo 4096, so 4095 is followed by 0.
- R3: The CRC word is computed over the header word and the packet words. The generator polynomial is 0x04C11DB7 and the register starts at all ones. Each word is fed most significant bit first, and the final register value is inverted.
- R4: Let H be the oldest held sequence number and C the number of sent, still-held packets. A report with number N is accepted when (N + 1 − H) mod 4096 ≤ C, and it then releases every packet up to and including N. Any other report is ignored and changes nothing. A released packet is never sent again.
- R5: At most `SLOTS` packets are held at once. While the store is full, `s_ready` is low. It returns high in the cycle after an acknowledgement frees a slot.
- R6: An accepted negative acknowledgement with number N first releases through N. It then re-sends every remaining held packet, starting at N+1, in original order, with unchanged sequence number, words and CRC.
- R7: If packets are outstanding and no acknowledgement makes progress for `TIMEOUT` cycles, every held packet is sent again in original order.
- R8: From the cycle after a replay is requested until the replay's last packet has ended, `s_ready` is low. A packet offered in that time is sent only after all replayed packets.
- R9: While `m_valid` is high and `m_ready` is low, the output word and its markers stay unchanged.
- R10: After reset, `m_valid` is low and `s_ready` is high.
- R11: An acknowledgement that releases at least one packet restarts the replay timer. A timeout replay therefore starts no sooner than `TIMEOUT` cycles after the last progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Source word valid |
| s_ready | output | 1 | Block accepts a source word |
| s_data | input | 32 | Source word |
| s_first | input | 1 | First word of a source packet |
| s_last | input | 1 | Last word of a source packet |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Link accepts the output word |
| m_data | output | 32 | Output word (header, packet word or CRC) |
| m_first | output | 1 | Header word of a frame |
| m_last | output | 1 | CRC word of a frame |
| ack_valid | input | 1 | Acknowledgement report valid (one cycle) |
| ack_nak | input | 1 | Report is a negative acknowledgement |
| ack_seq | input | 12 | Sequence number carried by the report |

## Verification
The sender is driven with packets of one to eight words. Some runs use a link that is always ready and some use a periodically stalling link, which shows whether framing and the CRC survive backpressure. Replays are triggered three ways: a negative acknowledgement after a partial release, one that names the number just before the oldest held packet, and a timer expiry after a partial acknowledgement. Comparing the replayed frames with the original ones shows whether the rewind point and the ordering are right. An out-of-range report is followed by a replay whose contents show that it released nothing. A long run past 4096 packets exposes wrap faults in the numbering and in the acceptance window.

// File: rtl/lrt_pkg.sv
// Package: shared constants, the per-word CRC step and the sender state type.
// Assumes a 32-bit link word; the CRC is fed most significant bit first.
package lrt_pkg;
    localparam int          WORD_W   = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_HDR,
        TX_BODY,
        TX_CRC
    } tx_state_t;

    // Advance the CRC register over one full word, most significant bit first.
    function automatic logic [31:0] crc_step(input logic [31:0] crc_in,
                                             input logic [WORD_W-1:0] word);
        logic [31:0] c;
        logic        fb;
        c = crc_in;
        for (int b = WORD_W - 1; b >= 0; b--) begin
            fb = c[31] ^ word[b];
            c  = {c[30:0], 1'b0};
            if (fb) begin
                c = c ^ CRC_POLY;
            end
        end
        return c;
    endfunction
endpackage

// File: rtl/lrt_store.sv
// Module: replay store. It writes source packets into fixed slots, one slot per packet,
// and gives random read access to the stored words for the sender.
// Assumes SLOTS is a power of two (at least 2) and that packets are at most MAX_WORDS long.
// A packet that reaches MAX_WORDS words is closed even without its last marker.
module lrt_store
    import lrt_pkg::*;
#(
    parameter  int SLOTS     = 4,
    parameter  int MAX_WORDS = 8,
    localparam int SLOT_W    = $clog2(SLOTS),
    localparam int PTR_W     = SLOT_W + 1,
    localparam int IDX_W     = $clog2(MAX_WORDS),
    localparam int LEN_W     = $clog2(MAX_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              block,
    input  logic [PTR_W-1:0]  head_ptr,
    output logic [PTR_W-1:0]  tail_ptr,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic [LEN_W-1:0]  rd_len
);
    logic [WORD_W-1:0] mem  [SLOTS][MAX_WORDS];
    logic [LEN_W-1:0]  lens [SLOTS];
    logic [IDX_W-1:0]  wcnt;
    logic [IDX_W-1:0]  wr_idx;
    logic [SLOT_W-1:0] wr_slot;
    logic [PTR_W-1:0]  used;
    logic              take;
    logic              close;

    // Derive occupancy, the write position and the acceptance condition.
    always_comb begin
        used     = tail_ptr - head_ptr;
        in_ready = (used != PTR_W'(SLOTS)) && !block;
        wr_idx   = in_first ? '0 : wcnt;
        wr_slot  = tail_ptr[SLOT_W-1:0];
        take     = in_valid && in_ready;
        close    = in_last || (wr_idx == IDX_W'(MAX_WORDS - 1));
    end

    // Write accepted words and the packet length into the slot being filled.
    always_ff @(posedge clk) begin
        if (take) begin
            mem[wr_slot][wr_idx] <= in_data;
            if (close) begin
                lens[wr_slot] <= LEN_W'(wr_idx) + LEN_W'(1);
            end
        end
    end

    // Track the word count in the open packet and commit a packet on its last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_ptr <= '0;
            wcnt     <= '0;
        end else if (take) begin
            if (close) begin
                tail_ptr <= tail_ptr + PTR_W'(1);
                wcnt     <= '0;
            end else begin
                wcnt <= wr_idx + IDX_W'(1);
            end
        end
    end

    // Give the sender a combinational read of the selected word and length.
    always_comb begin
        rd_word = mem[rd_slot][rd_idx];
        rd_len  = lens[rd_slot];
    end
endmodule

// File: rtl/lrt_ack.sv
// Module: acknowledgement tracker. It checks each report against the window of
// sent-but-held packets, releases packets cumulatively, runs the replay timer and
// raises a replay request on a negative acknowledgement or on timer expiry.
// Assumes reports last one cycle and sequence numbers are wider than the slot pointers.
module lrt_ack #(
    parameter  int SEQ_W   = 12,
    parameter  int SLOTS   = 4,
    parameter  int TIMEOUT = 200,
    localparam int PTR_W   = $clog2(SLOTS) + 1,
    localparam int TMR_W   = $clog2(TIMEOUT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_valid,
    input  logic             ack_nak,
    input  logic [SEQ_W-1:0] ack_seq,
    input  logic [PTR_W-1:0] sent_ptr,
    input  logic             replaying,
    input  logic             replay_take,
    output logic [PTR_W-1:0] head_ptr,
    output logic [SEQ_W-1:0] head_seq,
    output logic             replay_req
);
    logic [SEQ_W-1:0] span;
    logic [PTR_W-1:0] held_sent;
    logic [PTR_W-1:0] remain;
    logic             accept;
    logic             progress;
    logic             nak_go;
    logic             run;
    logic             fire;
    logic [TMR_W-1:0] tmr;

    // Decide whether a report lies in the window and what it releases.
    always_comb begin
        span      = ack_seq + SEQ_W'(1) - head_seq;
        held_sent = sent_ptr - head_ptr;
        accept    = ack_valid && (span <= SEQ_W'(held_sent));
        progress  = accept && (span != '0);
        remain    = held_sent - PTR_W'(span);
        nak_go    = accept && ack_nak && (remain != '0);
        run       = (held_sent != '0) && !replay_req && !replaying;
        fire      = run && !progress && (tmr == TMR_W'(TIMEOUT - 1));
    end

    // Move the oldest-held pointer and its sequence number on accepted reports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_ptr <= '0;
            head_seq <= '0;
        end else if (accept) begin
            head_ptr <= head_ptr + PTR_W'(span);
            head_seq <= head_seq + span;
        end
    end

    // Count idle cycles with packets outstanding; restart on progress or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr <= '0;
        end else if (progress || !run || fire) begin
            tmr <= '0;
        end else begin
            tmr <= tmr + TMR_W'(1);
        end
    end

    // Hold a replay request until the sender takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            replay_req <= 1'b0;
        end else if (nak_go || fire) begin
            replay_req <= 1'b1;
        end else if (replay_take) begin
            replay_req <= 1'b0;
        end
    end
endmodule

// File: rtl/lrt_send.sv
// Module: frame sender. It walks the store in order, emitting header, packet words and
// CRC for each slot. On a replay request it rewinds to the oldest held slot
// between frames. A frame in progress is never cut short.
// Assumes the store and tracker pointers stay within one slot window of each other.
module lrt_send
    import lrt_pkg::*;
#(
    parameter  int SEQ_W     = 12,
    parameter  int SLOTS     = 4,
    parameter  int MAX_WORDS = 8,
    localparam int SLOT_W    = $clog2(SLOTS),
    localparam int PTR_W     = SLOT_W + 1,
    localparam int IDX_W     = $clog2(MAX_WORDS),
    localparam int LEN_W     = $clog2(MAX_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTR_W-1:0]  head_ptr,
    input  logic [SEQ_W-1:0]  head_seq,
    input  logic [PTR_W-1:0]  tail_ptr,
    input  logic              replay_req,
    output logic              replay_take,
    output logic              replaying,
    output logic [PTR_W-1:0]  sent_ptr,
    output logic [SLOT_W-1:0] rd_slot,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [WORD_W-1:0] rd_word,
    input  logic [LEN_W-1:0]  rd_len,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_first,
    output logic              out_last,
    input  logic              out_ready
);
    tx_state_t         state;
    logic [PTR_W-1:0]  tx_ptr;
    logic [SEQ_W-1:0]  seq_lat;
    logic [IDX_W-1:0]  widx;
    logic [31:0]       crc;
    logic              hs;
    logic              idle;
    logic              behind;
    logic              body_end;

    // Status and control terms shared by the output mux and the state update.
    always_comb begin
        idle        = (state == TX_IDLE);
        hs          = out_valid && out_ready;
        behind      = (sent_ptr - tx_ptr) > (sent_ptr - head_ptr);
        replay_take = idle && replay_req;
        replaying   = (tx_ptr != sent_ptr);
        body_end    = (LEN_W'(widx) + LEN_W'(1)) == rd_len;
        rd_slot     = tx_ptr[SLOT_W-1:0];
        rd_idx      = widx;
    end

    // Select the output word for the current frame phase.
    always_comb begin
        out_valid = !idle;
        out_first = (state == TX_HDR);
        out_last  = (state == TX_CRC);
        unique case (state)
            TX_HDR:  out_data = {{(WORD_W - SEQ_W){1'b0}}, seq_lat};
            TX_BODY: out_data = rd_word;
            TX_CRC:  out_data = ~crc;
            default: out_data = '0;
        endcase
    end

    // Frame state machine, send pointer, first-send boundary and running CRC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= TX_IDLE;
            tx_ptr   <= '0;
            sent_ptr <= '0;
            seq_lat  <= '0;
            widx     <= '0;
            crc      <= CRC_INIT;
        end else begin
            unique case (state)
                TX_IDLE: begin
                    if (replay_req || behind) begin
                        tx_ptr <= head_ptr;
                    end else if (tx_ptr != tail_ptr) begin
                        seq_lat <= head_seq + SEQ_W'(tx_ptr - head_ptr);
                        crc     <= CRC_INIT;
                        widx    <= '0;
                        state   <= TX_HDR;
                    end
                end
                TX_HDR: begin
                    if (hs) begin
                        crc   <= crc_step(crc, out_data);
                        state <= TX_BODY;
                    end
                end
                TX_BODY: begin
                    if (hs) begin
                        crc <= crc_step(crc, rd_word);
                        if (body_end) begin
                            state <= TX_CRC;
                        end else begin
                            widx <= widx + IDX_W'(1);
                        end
                    end
                end
                TX_CRC: begin
                    if (hs) begin
                        state  <= TX_IDLE;
                        tx_ptr <= tx_ptr + PTR_W'(1);
                        if (tx_ptr == sent_ptr) begin
                            sent_ptr <= sent_ptr + PTR_W'(1);
                        end
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lrt_replay_tx.sv
// Module: top of the link-layer replay transmitter. It ties together the replay store,
// the acknowledgement tracker and the frame sender.
// Assumes SLOTS is a power of two of at least 2, MAX_WORDS of at least 2, TIMEOUT of at least 2.
module lrt_replay_tx
    import lrt_pkg::*;
#(
    parameter  int SEQ_W     = 12,
    parameter  int SLOTS     = 4,
    parameter  int MAX_WORDS = 8,
    parameter  int TIMEOUT   = 200,
    localparam int SLOT_W    = $clog2(SLOTS),
    localparam int PTR_W     = SLOT_W + 1,
    localparam int IDX_W     = $clog2(MAX_WORDS),
    localparam int LEN_W     = $clog2(MAX_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [WORD_W-1:0] s_data,
    input  logic              s_first,
    input  logic              s_last,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [WORD_W-1:0] m_data,
    output logic              m_first,
    output logic              m_last,
    input  logic              ack_valid,
    input  logic              ack_nak,
    input  logic [SEQ_W-1:0]  ack_seq
);
    logic [PTR_W-1:0]  head_ptr;
    logic [PTR_W-1:0]  tail_ptr;
    logic [PTR_W-1:0]  sent_ptr;
    logic [SEQ_W-1:0]  head_seq;
    logic              replay_req;
    logic              replay_take;
    logic              replaying;
    logic              blocked;
    logic [SLOT_W-1:0] rd_slot;
    logic [IDX_W-1:0]  rd_idx;
    logic [WORD_W-1:0] rd_word;
    logic [LEN_W-1:0]  rd_len;

    // Hold the source off from replay request until the replay has finished.
    assign blocked = replay_req | replaying;

    lrt_store #(
        .SLOTS     (SLOTS),
        .MAX_WORDS (MAX_WORDS)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (s_valid),
        .in_data  (s_data),
        .in_first (s_first),
        .in_last  (s_last),
        .in_ready (s_ready),
        .block    (blocked),
        .head_ptr (head_ptr),
        .tail_ptr (tail_ptr),
        .rd_slot  (rd_slot),
        .rd_idx   (rd_idx),
        .rd_word  (rd_word),
        .rd_len   (rd_len)
    );

    lrt_ack #(
        .SEQ_W   (SEQ_W),
        .SLOTS   (SLOTS),
        .TIMEOUT (TIMEOUT)
    ) u_ack (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_valid   (ack_valid),
        .ack_nak     (ack_nak),
        .ack_seq     (ack_seq),
        .sent_ptr    (sent_ptr),
        .replaying   (replaying),
        .replay_take (replay_take),
        .head_ptr    (head_ptr),
        .head_seq    (head_seq),
        .replay_req  (replay_req)
    );

    lrt_send #(
        .SEQ_W     (SEQ_W),
        .SLOTS     (SLOTS),
        .MAX_WORDS (MAX_WORDS)
    ) u_send (
        .clk         (clk),
        .rst_n       (rst_n),
        .head_ptr    (head_ptr),
        .head_seq    (head_seq),
        .tail_ptr    (tail_ptr),
        .replay_req  (replay_req),
        .replay_take (replay_take),
        .replaying   (replaying),
        .sent_ptr    (sent_ptr),
        .rd_slot     (rd_slot),
        .rd_idx      (rd_idx),
        .rd_word     (rd_word),
        .rd_len      (rd_len),
        .out_valid   (m_valid),
        .out_data    (m_data),
        .out_first   (m_first),
        .out_last    (m_last),
        .out_ready   (m_ready)
    );
endmodule

// File: rtl/lrt_replay_tx_chk.sv
// Module: property checker for the replay transmitter, attached to the top by bind.
// Assumes the bound pointer signals are those of the store, tracker and sender.
module lrt_replay_tx_chk #(
    parameter  int SLOTS = 4,
    localparam int PTR_W = $clog2(SLOTS) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             s_ready,
    input logic             m_valid,
    input logic             m_ready,
    input logic [31:0]      m_data,
    input logic             m_first,
    input logic             m_last,
    input logic             blocked,
    input logic [PTR_W-1:0] head_ptr,
    input logic [PTR_W-1:0] tail_ptr,
    input logic [PTR_W-1:0] sent_ptr
);
    // R5: the store never holds more than SLOTS packets.
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        PTR_W'(tail_ptr - head_ptr) <= PTR_W'(SLOTS));

    // R5: a full store stalls the source.
    a_r5_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (PTR_W'(tail_ptr - head_ptr) == PTR_W'(SLOTS)) |-> !s_ready);

    // R4: releases never pass packets that have not been sent once.
    a_r4_release_sent: assert property (@(posedge clk) disable iff (!rst_n)
        PTR_W'(tail_ptr - sent_ptr) <= PTR_W'(tail_ptr - head_ptr));

    // R8: no source word is taken while a replay is pending or running.
    a_r8_block_source: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> !s_ready);

    // R9: a stalled output word and its markers hold.
    a_r9_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_first) && $stable(m_last)));

    // R1: header and CRC words are never the same word.
    a_r1_frame_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_first) |-> !m_last);
endmodule

bind lrt_replay_tx lrt_replay_tx_chk #(
    .SLOTS (SLOTS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_ready  (s_ready),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .m_data   (m_data),
    .m_first  (m_first),
    .m_last   (m_last),
    .blocked  (blocked),
    .head_ptr (head_ptr),
    .tail_ptr (tail_ptr),
    .sent_ptr (sent_ptr)
);

// File: tb/test_lrt_replay_tx.sv
module test_lrt_replay_tx;
    localparam int CLK_PERIOD = 10;
    localparam int SEQ_W      = 12;
    localparam int SLOTS      = 4;
    localparam int MAX_WORDS  = 8;
    localparam int TIMEOUT    = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [31:0] s_data = '0;
    logic        s_first = 1'b0;
    logic        s_last = 1'b0;
    logic        m_valid;
    logic        m_ready = 1'b1;
    logic [31:0] m_data;
    logic        m_first;
    logic        m_last;
    logic        ack_valid = 1'b0;
    logic        ack_nak = 1'b0;
    logic [11:0] ack_seq = '0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit bp_mode = 0;
    int pat_cnt = 0;

    typedef struct {
        logic [31:0] w [0:15];
        int          n;
        bit          marks_ok;
    } frame_t;

    frame_t fq[$];
    frame_t cur;
    bit     stall_prev = 0;
    logic [31:0] stall_data;

    lrt_replay_tx #(
        .SEQ_W     (SEQ_W),
        .SLOTS     (SLOTS),
        .MAX_WORDS (MAX_WORDS),
        .TIMEOUT   (TIMEOUT)
    ) i_lrt_replay_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_valid   (s_valid),
        .s_ready   (s_ready),
        .s_data    (s_data),
        .s_first   (s_first),
        .s_last    (s_last),
        .m_valid   (m_valid),
        .m_ready   (m_ready),
        .m_data    (m_data),
        .m_first   (m_first),
        .m_last    (m_last),
        .ack_valid (ack_valid),
        .ack_nak   (ack_nak),
        .ack_seq   (ack_seq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pay(input int k, input int j);
        return (32'(k) * 32'h9E37_79B1) ^ (32'(j) * 32'h0100_0193) ^ 32'hC0DE_0000;
    endfunction

    function automatic int plen(input int k);
        return (k % MAX_WORDS) + 1;
    endfunction

    function automatic logic [11:0] sq(input int k);
        return 12'(k);
    endfunction

    // Bench CRC per R3: poly 0x04C11DB7, init all ones, MSB first, inverted result.
    function automatic logic [31:0] ref_crc(input frame_t f, input int upto);
        logic [31:0] c;
        logic fb;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < upto; i++) begin
            for (int b = 31; b >= 0; b--) begin
                fb = c[31] ^ f.w[i][b];
                c  = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        end
        return ~c;
    endfunction

    // Output side: set the ready pattern, check stalled words (R9), collect frames.
    always @(negedge clk) begin
        if (bp_mode) begin
            m_ready = ((pat_cnt % 3) != 2);
            pat_cnt++;
        end else begin
            m_ready = 1'b1;
        end
        if (stall_prev) begin
            chk(m_valid && (m_data == stall_data), "R9", "stalled word changed", m_data, stall_data);
        end
        stall_prev = m_valid && !m_ready;
        stall_data = m_data;
        if (m_valid && m_ready) begin
            if (cur.n == 0) begin
                cur.marks_ok = m_first && !m_last;
            end else if (m_first) begin
                cur.marks_ok = 0;
            end
            if (cur.n < 16) cur.w[cur.n] = m_data;
            cur.n++;
            if (m_last) begin
                fq.push_back(cur);
                cur.n = 0;
            end
        end
    end

    task automatic send_pkt(input int k);
        for (int j = 0; j < plen(k); j++) begin
            @(negedge clk);
            s_valid = 1'b1;
            s_data  = pay(k, j);
            s_first = (j == 0);
            s_last  = (j == plen(k) - 1);
            while (!s_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        s_valid = 1'b0;
        s_first = 1'b0;
        s_last  = 1'b0;
    endtask

    task automatic send_ack(input logic [11:0] n, input bit nak);
        @(negedge clk);
        ack_valid = 1'b1;
        ack_nak   = nak;
        ack_seq   = n;
        @(negedge clk);
        ack_valid = 1'b0;
        ack_nak   = 1'b0;
    endtask

    // Wait for the next frame and check it against packet k (R1, R3, sequence tag given).
    task automatic expect_frame(input int k, input string seq_req);
        frame_t f;
        int waited;
        bit body_ok;
        waited = 0;
        while (fq.size() == 0 && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        if (fq.size() == 0) begin
            chk(0, seq_req, "no frame arrived", 32'(0), 32'(k));
            return;
        end
        f = fq.pop_front();
        chk(f.n == plen(k) + 2, "R1", "frame length", 32'(f.n), 32'(plen(k) + 2));
        chk(f.marks_ok, "R1", "first/last markers", 32'(f.marks_ok), 32'(1));
        chk(f.w[0] == {20'h0, sq(k)}, seq_req, "header sequence", f.w[0], {20'h0, sq(k)});
        if (f.n == plen(k) + 2) begin
            body_ok = 1;
            for (int j = 0; j < plen(k); j++) begin
                if (f.w[j + 1] != pay(k, j)) body_ok = 0;
            end
            chk(body_ok, "R1", "packet words", f.w[1], pay(k, 0));
            chk(f.w[f.n - 1] == ref_crc(f, f.n - 1), "R3", "crc word", f.w[f.n - 1], ref_crc(f, f.n - 1));
        end
    endtask

    task automatic quiet(input int cycles, input string req);
        repeat (cycles) @(negedge clk);
        chk(fq.size() == 0 && !m_valid, req, "unexpected frame", 32'(fq.size()), 32'(0));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!m_valid, "R10", "m_valid after reset", 32'(m_valid), 32'(0));
        chk(s_ready, "R10", "s_ready after reset", 32'(s_ready), 32'(1));
    endtask

    task automatic t_basic;
        for (int k = 0; k < 3; k++) send_pkt(k);
        for (int k = 0; k < 3; k++) expect_frame(k, "R2");
        send_ack(sq(2), 0);
        quiet(TIMEOUT + 50, "R4");
    endtask

    task automatic t_full;
        for (int k = 3; k < 7; k++) send_pkt(k);
        @(negedge clk);
        s_valid = 1'b1;
        s_first = 1'b1;
        s_last  = 1'b0;
        s_data  = pay(7, 0);
        begin
            bit stalled;
            stalled = 1;
            repeat (20) begin
                @(negedge clk);
                if (s_ready) stalled = 0;
            end
            chk(stalled, "R5", "s_ready while full", 32'(!stalled), 32'(0));
        end
        send_ack(sq(3), 0);
        chk(s_ready, "R5", "s_ready after release", 32'(s_ready), 32'(1));
        send_pkt(7);
        for (int k = 3; k < 8; k++) expect_frame(k, "R5");
        send_ack(sq(7), 0);
    endtask

    task automatic t_nak;
        for (int k = 8; k < 12; k++) send_pkt(k);
        for (int k = 8; k < 12; k++) expect_frame(k, "R2");
        send_ack(sq(8), 1);
        for (int k = 9; k < 12; k++) expect_frame(k, "R6");
        send_ack(sq(11), 0);
        quiet(20, "R6");
    endtask

    task automatic t_ignore;
        for (int k = 12; k < 14; k++) send_pkt(k);
        for (int k = 12; k < 14; k++) expect_frame(k, "R2");
        send_ack(sq(18), 0);
        send_ack(sq(11), 1);
        for (int k = 12; k < 14; k++) expect_frame(k, "R4");
        send_ack(sq(13), 0);
        quiet(TIMEOUT + 50, "R4");
    endtask

    task automatic t_timeout;
        int t_ack;
        for (int k = 14; k < 16; k++) send_pkt(k);
        for (int k = 14; k < 16; k++) expect_frame(k, "R2");
        repeat (60) @(negedge clk);
        send_ack(sq(14), 0);
        t_ack = cyc;
        expect_frame(15, "R7");
        chk((cyc - t_ack) >= TIMEOUT, "R11", "replay too early", 32'(cyc - t_ack), 32'(TIMEOUT));
        send_ack(sq(15), 0);
    endtask

    task automatic t_block;
        bp_mode = 1;
        for (int k = 16; k < 19; k++) send_pkt(k);
        for (int k = 16; k < 19; k++) expect_frame(k, "R2");
        send_ack(sq(15), 1);
        chk(!s_ready, "R8", "s_ready during replay", 32'(s_ready), 32'(0));
        send_pkt(19);
        for (int k = 16; k < 19; k++) expect_frame(k, "R8");
        expect_frame(19, "R8");
        send_ack(sq(19), 0);
        bp_mode = 0;
    endtask

    task automatic t_wrap;
        for (int k = 20; k < 4116; k++) begin
            send_pkt(k);
            expect_frame(k, "R2");
            send_ack(sq(k), 0);
        end
        quiet(20, "R2");
    endtask

    initial begin
        cur.n = 0;
        cur.marks_ok = 0;
        t_reset();
        t_basic();
        t_full();
        t_nak();
        t_ignore();
        t_timeout();
        t_block();
        t_wrap();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        chk(0, "R1", "watchdog expired", 32'(cyc), 32'(0));
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule